// File: doc/BRIEF.md
# Memory Access Alignment Checker and Splitter

This block sits between a load/store issue stage and the data cache and translation path. Each incoming request carries a 64-bit byte address, a byte count from 1 to 16 and an access class. The block first decides whether the request breaks the alignment rule of its class. A faulting request is dropped. It produces a one-cycle fault pulse and its address is stored in a fault address register that software can read.

A request that does not fault leaves the block as one or two sub-requests on a valid/ready port. Each sub-request is confined to one cache line and is described by the line base address, a byte offset within the line and a byte length. A request that runs past the end of a line is cut at that boundary, and the lower half is always sent first. When the request also runs past a 4 KB page boundary, both halves carry a flag saying that two translation lookups are needed. The block takes no new request until the last sub-request of the current one has been handed off.

Top module: `masp_align_split`

## Requirements
- R1: Class codes 0 (normal), 3 (SIMD) and the unused codes 5, 6 and 7 never fault for any start address when the size is between 1 and 16.
- R2: Class code 1 (atomic/exclusive) faults unless the size is 1, 2, 4, 8 or 16 and the address is a multiple of the size.
- R3: Class code 2 (floating point) faults only when the size is 16 and the low four address bits are not all zero. Sizes 4 and 8 are accepted at any address.
- R4: Class code 4 (instruction fetch) faults whenever either of address bits 1 and 0 is set.
- R5: A size of 0, or a size above 16, faults for every class.
- R6: A non-faulting request with (address mod 64) + size <= 64 produces exactly one sub-request. Its fields are: line base = address with its low 6 bits cleared, offset = address mod 64, length = size, second = 0, last = 1.
- R7: A non-faulting request with (address mod 64) + size > 64 produces two sub-requests, lower address first. The first has the request's line base, offset = address mod 64, length = 64 - offset, second = 0 and last = 0. The second has line base + 64 (modulo 2^64), offset 0, the remaining length, second = 1 and last = 1.
- R8: The two-lookup flag is 1 on every sub-request of a request with (address mod 4096) + size > 4096, and 0 on every sub-request of any other request.
- R9: While sub_valid is high and sub_ready is low, every sub-request field holds its value. req_ready is low from the cycle after a non-faulting acceptance until the cycle after the last sub-request is handed off.
- R10: A faulting request produces no sub-request, and fault_pulse is high for exactly the one cycle after it is accepted.
- R11: far_addr takes the faulting address in the same cycle as the fault pulse and keeps its value until the next fault. A synchronous reset clears it to zero. After reset, req_ready is 1 and sub_valid and fault_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 64 | Request start byte address |
| req_size | input | 5 | Request byte count, legal 1 to 16 |
| req_class | input | 3 | Access class code |
| sub_valid | output | 1 | Sub-request offered |
| sub_ready | input | 1 | Downstream takes the sub-request |
| sub_line_addr | output | 64 | Line base address of the sub-request |
| sub_offset | output | log2(LINE_BYTES) | Byte offset within the line |
| sub_len | output | 5 | Byte count of the sub-request |
| sub_second | output | 1 | Sub-request is the upper half of a split |
| sub_last | output | 1 | Final sub-request of the request |
| sub_two_lookup | output | 1 | Request spans a 4 KB page boundary |
| fault_pulse | output | 1 | One-cycle alignment fault indication |
| far_addr | output | 64 | Address of the most recent fault |

## Verification
The bench builds the block with a 64-byte line and a 4096-byte page, passed explicitly and equal to the defaults. With those values the addresses just below 0x1000 and 0x3000 reach a line split that is also a page split, while offsets such as 0x103E reach a line split with no page split. An address near 2^64 reaches the wrap of the second line base. Three downstream ready patterns (always ready, every other cycle, two of every three) hold the split halves under backpressure. Atomic, floating-point and fetch requests are placed on both sides of each alignment rule.

// File: rtl/masp_pkg.sv
package masp_pkg;
    localparam int ADDR_W    = 64;
    localparam int SIZE_W    = 5;
    localparam int MAX_BYTES = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SIZE_W-1:0] size_t;

    typedef enum logic [2:0] {
        CLS_NORMAL = 3'd0,
        CLS_ATOMIC = 3'd1,
        CLS_FP     = 3'd2,
        CLS_SIMD   = 3'd3,
        CLS_IFETCH = 3'd4
    } acc_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TAIL
    } split_state_e;

    typedef struct packed {
        addr_t start;
        size_t len;
        logic  second;
        logic  last;
        logic  two_lookup;
    } sub_req_t;

    function automatic logic size_legal(size_t s);
        return (s != '0) && (s <= size_t'(MAX_BYTES));
    endfunction

    function automatic logic size_is_pow2(size_t s);
        return (s != '0) && ((s & (s - size_t'(1))) == '0);
    endfunction

    function automatic logic misaligned_to(size_t addr_lo, size_t s);
        return (addr_lo & (s - size_t'(1))) != '0;
    endfunction
endpackage

// File: rtl/masp_fault_check.sv
module masp_fault_check
    import masp_pkg::*;
(
    input  logic [SIZE_W-1:0] addr_lo_i,
    input  size_t             size_i,
    input  logic [2:0]        class_i,
    output logic              fault_o
);
    acc_class_e cls;
    logic       class_fault;

    assign cls = acc_class_e'(class_i);

    always_comb begin
        class_fault = 1'b0;
        case (cls)
            CLS_ATOMIC: class_fault = !size_is_pow2(size_i) || misaligned_to(addr_lo_i, size_i);
            CLS_FP:     class_fault = (size_i == size_t'(MAX_BYTES)) && (addr_lo_i[3:0] != 4'd0);
            CLS_IFETCH: class_fault = (addr_lo_i[1:0] != 2'd0);
            default:    class_fault = 1'b0;
        endcase
    end

    assign fault_o = !size_legal(size_i) || class_fault;
endmodule

// File: rtl/masp_bound_cross.sv
module masp_bound_cross
    import masp_pkg::*;
#(
    parameter int GRAN_BYTES = 64
) (
    input  logic [$clog2(GRAN_BYTES)-1:0] off_i,
    input  size_t                         size_i,
    output logic                          cross_o
);
    localparam int OW = $clog2(GRAN_BYTES);
    localparam int SW = OW + 2;

    logic [SW-1:0] reach;

    assign reach   = SW'(off_i) + SW'(size_i);
    assign cross_o = reach > SW'(GRAN_BYTES);
endmodule

// File: rtl/masp_split_calc.sv
module masp_split_calc
    import masp_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096
) (
    input  addr_t    addr_i,
    input  size_t    size_i,
    output sub_req_t head_o,
    output sub_req_t tail_o
);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int HW     = LINE_W + 1;

    logic [1:0] cross_vec;
    logic [HW-1:0] room;
    size_t head_len;
    addr_t line_base;

    for (genvar g = 0; g < 2; g++) begin : g_bound
        localparam int GB  = (g == 0) ? LINE_BYTES : PAGE_BYTES;
        localparam int GBW = $clog2(GB);
        masp_bound_cross #(.GRAN_BYTES(GB)) u_bc (
            .off_i   (addr_i[GBW-1:0]),
            .size_i  (size_i),
            .cross_o (cross_vec[g])
        );
    end

    assign room      = HW'(LINE_BYTES) - HW'(addr_i[LINE_W-1:0]);
    assign head_len  = cross_vec[0] ? SIZE_W'(room) : size_i;
    assign line_base = addr_i & ~addr_t'(LINE_BYTES - 1);

    always_comb begin
        head_o.start      = addr_i;
        head_o.len        = head_len;
        head_o.second     = 1'b0;
        head_o.last       = !cross_vec[0];
        head_o.two_lookup = cross_vec[1];

        tail_o.start      = line_base + addr_t'(LINE_BYTES);
        tail_o.len        = size_i - head_len;
        tail_o.second     = 1'b1;
        tail_o.last       = 1'b1;
        tail_o.two_lookup = cross_vec[1];
    end
endmodule

// File: rtl/masp_far.sv
module masp_far
    import masp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  capture_i,
    input  addr_t addr_i,
    output addr_t far_o
);
    always_ff @(posedge clk) begin
        if (rst)
            far_o <= '0;
        else if (capture_i)
            far_o <= addr_i;
    end

    // R11: value only moves on a capture
    assert_far_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(capture_i)) |-> $stable(far_o));
endmodule

// File: rtl/masp_align_split.sv
module masp_align_split
    import masp_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [63:0]                   req_addr,
    input  logic [4:0]                    req_size,
    input  logic [2:0]                    req_class,
    output logic                          sub_valid,
    input  logic                          sub_ready,
    output logic [63:0]                   sub_line_addr,
    output logic [$clog2(LINE_BYTES)-1:0] sub_offset,
    output logic [4:0]                    sub_len,
    output logic                          sub_second,
    output logic                          sub_last,
    output logic                          sub_two_lookup,
    output logic                          fault_pulse,
    output logic [63:0]                   far_addr
);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int FW     = LINE_W + 2;

    split_state_e state_q;
    sub_req_t     head_c, tail_c, head_q, tail_q, cur;
    logic         fault_c, accept, handoff, fault_q;

    masp_fault_check u_fault (
        .addr_lo_i (req_addr[SIZE_W-1:0]),
        .size_i    (req_size),
        .class_i   (req_class),
        .fault_o   (fault_c)
    );

    masp_split_calc #(.LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_split (
        .addr_i (req_addr),
        .size_i (req_size),
        .head_o (head_c),
        .tail_o (tail_c)
    );

    masp_far u_far (
        .clk       (clk),
        .rst       (rst),
        .capture_i (accept && fault_c),
        .addr_i    (req_addr),
        .far_o     (far_addr)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign sub_valid = (state_q != ST_IDLE);
    assign handoff   = sub_valid && sub_ready;
    assign cur       = (state_q == ST_TAIL) ? tail_q : head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fault_q <= 1'b0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            fault_q <= accept && fault_c;
            case (state_q)
                ST_IDLE: begin
                    if (accept && !fault_c) begin
                        head_q  <= head_c;
                        tail_q  <= tail_c;
                        state_q <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (handoff)
                        state_q <= head_q.last ? ST_IDLE : ST_TAIL;
                end
                ST_TAIL: begin
                    if (handoff)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sub_line_addr  = cur.start & ~addr_t'(LINE_BYTES - 1);
    assign sub_offset     = cur.start[LINE_W-1:0];
    assign sub_len        = cur.len;
    assign sub_second     = cur.second;
    assign sub_last       = cur.last;
    assign sub_two_lookup = cur.two_lookup;
    assign fault_pulse    = fault_q;

    // R1: normal and SIMD classes with a legal size never fault
    assert_plain_nofault_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_class == 3'd0 || req_class == 3'd3) && req_size != 5'd0 && req_size <= 5'd16)
        |=> !fault_pulse);

    // R4: misaligned fetch always faults
    assert_fetch_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && req_class == 3'd4 && req_addr[1:0] != 2'd0) |=> fault_pulse);

    // R7: a sub-request never runs past its line
    assert_fits_line_R7: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (FW'(sub_offset) + FW'(sub_len) <= FW'(LINE_BYTES)));

    // R7: upper half starts at the line base
    assert_tail_base_R7: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_second) |-> (sub_offset == '0));

    // R9: fields hold under backpressure
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_line_addr) &&
                                       $stable(sub_offset) && $stable(sub_len)));

    // R9: last handoff frees the request port
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_ready && sub_last) |=> req_ready);

    // R10: fault pulse follows an accepted request and no sub-request goes out
    assert_fault_src_R10: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> ($past(req_valid && req_ready) && !sub_valid));
endmodule

// File: tb/masp_align_split_tb.sv
module masp_align_split_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_B     = 64;
    localparam int PAGE_B     = 4096;

    typedef struct {
        logic [63:0] line;
        int          off;
        int          len;
        bit          second;
        bit          last;
        bit          twol;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [4:0]  req_size = '0;
    logic [2:0]  req_class = '0;
    logic        sub_valid;
    logic        sub_ready = 1'b0;
    logic [63:0] sub_line_addr;
    logic [5:0]  sub_offset;
    logic [4:0]  sub_len;
    logic        sub_second, sub_last, sub_two_lookup;
    logic        fault_pulse;
    logic [63:0] far_addr;

    int nchk = 0;
    int nerr = 0;
    int ready_mode = 0;
    int cyc = 0;
    bit done = 0;
    logic [63:0] far_model = '0;
    exp_item_t q[$];
    string     tq[$];

    masp_align_split #(.LINE_BYTES(LINE_B), .PAGE_BYTES(PAGE_B)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_class(req_class),
        .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_line_addr(sub_line_addr),
        .sub_offset(sub_offset), .sub_len(sub_len), .sub_second(sub_second),
        .sub_last(sub_last), .sub_two_lookup(sub_two_lookup),
        .fault_pulse(fault_pulse), .far_addr(far_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_fault(logic [63:0] a, int sz, logic [2:0] c);
        if (sz < 1 || sz > 16) return 1'b1;
        case (c)
            3'd1: return !(sz == 1 || sz == 2 || sz == 4 || sz == 8 || sz == 16) ||
                         ((a % 64'(sz)) != 64'd0);
            3'd2: return (sz == 16) && (a[3:0] != 4'd0);
            3'd4: return a[1:0] != 2'd0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push_subs(logic [63:0] a, int sz, string tag);
        exp_item_t it;
        logic [63:0] base = a & ~64'(LINE_B - 1);
        int off = int'(a & 64'(LINE_B - 1));
        int poff = int'(a & 64'(PAGE_B - 1));
        bit pg = (poff + sz) > PAGE_B;
        if (off + sz <= LINE_B) begin
            it = '{line: base, off: off, len: sz, second: 1'b0, last: 1'b1, twol: pg};
            q.push_back(it); tq.push_back(tag);
        end else begin
            it = '{line: base, off: off, len: LINE_B - off, second: 1'b0, last: 1'b0, twol: pg};
            q.push_back(it); tq.push_back(tag);
            it = '{line: base + 64'(LINE_B), off: 0, len: sz - (LINE_B - off),
                   second: 1'b1, last: 1'b1, twol: pg};
            q.push_back(it); tq.push_back(tag);
        end
    endtask

    task automatic send(logic [63:0] a, int sz, logic [2:0] c, string tag);
        bit f = exp_fault(a, sz, c);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (!f) push_subs(a, sz, tag);
        req_valid = 1'b1; req_addr = a; req_size = 5'(sz); req_class = c;
        @(negedge clk);
        req_valid = 1'b0;
        chk(fault_pulse === f, tag, "fault_pulse", 64'(fault_pulse), 64'(f));
        if (f) begin
            far_model = a;
            chk(sub_valid === 1'b0, tag, "sub_valid on fault", 64'(sub_valid), 64'd0);
        end
        chk(far_addr === far_model, tag, "far_addr", far_addr, far_model);
    endtask

    task automatic drain();
        int guard = 0;
        while ((q.size() != 0 || !req_ready) && guard < 1000) begin
            @(negedge clk); guard++;
        end
        chk(q.size() == 0, "R9", "drain", 64'(q.size()), 64'd0);
    endtask

    task automatic reset_checks(string tag);
        chk(req_ready === 1'b1, tag, "req_ready after reset", 64'(req_ready), 64'd1);
        chk(sub_valid === 1'b0, tag, "sub_valid after reset", 64'(sub_valid), 64'd0);
        chk(fault_pulse === 1'b0, tag, "fault_pulse after reset", 64'(fault_pulse), 64'd0);
        chk(far_addr === 64'd0, tag, "far_addr after reset", far_addr, 64'd0);
    endtask

    // monitor: drives ready, checks stability and compares handed-off sub-requests
    initial begin
        bit stalled = 0;
        logic [63:0] s_line = '0;
        logic [5:0] s_off = '0;
        logic [4:0] s_len = '0;
        exp_item_t e;
        string t;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                sub_ready = 1'b0;
                stalled = 0;
            end else begin
                case (ready_mode)
                    0: sub_ready = 1'b1;
                    1: sub_ready = cyc[0];
                    default: sub_ready = (cyc % 3) != 0;
                endcase
                if (sub_valid) begin
                    chk(req_ready === 1'b0, "R9", "req_ready while busy", 64'(req_ready), 64'd0);
                    if (stalled) begin
                        chk(sub_line_addr === s_line, "R9", "hold line", sub_line_addr, s_line);
                        chk(sub_offset === s_off, "R9", "hold offset", 64'(sub_offset), 64'(s_off));
                        chk(sub_len === s_len, "R9", "hold len", 64'(sub_len), 64'(s_len));
                    end
                end
                if (sub_valid && sub_ready) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R10", "unexpected sub-request", sub_line_addr, 64'd0);
                    end else begin
                        e = q.pop_front();
                        t = tq.pop_front();
                        chk(sub_line_addr === e.line, t, "line", sub_line_addr, e.line);
                        chk(int'(sub_offset) == e.off, t, "offset", 64'(sub_offset), 64'(e.off));
                        chk(int'(sub_len) == e.len, t, "len", 64'(sub_len), 64'(e.len));
                        chk(sub_second === e.second, t, "second", 64'(sub_second), 64'(e.second));
                        chk(sub_last === e.last, t, "last", 64'(sub_last), 64'(e.last));
                        chk(sub_two_lookup === e.twol, "R8", "two_lookup",
                            64'(sub_two_lookup), 64'(e.twol));
                    end
                end
                stalled = sub_valid && !sub_ready;
                s_line = sub_line_addr; s_off = sub_offset; s_len = sub_len;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        reset_checks("R11");
        rst = 1'b0;
        for (int m = 0; m < 3; m++) begin
            ready_mode = m;
            send(64'h1000, 8, 3'd0, "R6");
            send(64'h1003, 4, 3'd0, "R1");
            send(64'h0000_0000_0000_203C, 16, 3'd0, "R7");
            send(64'h07F1, 16, 3'd3, "R7");
            send(64'h103E, 4, 3'd0, "R7");
            send(64'h0FFC, 8, 3'd0, "R8");
            send(64'h2FFF, 16, 3'd3, "R8");
            send(64'h0FF0, 16, 3'd0, "R8");
            send(64'h5007, 9, 3'd6, "R1");
            send(64'hFFFF_FFFF_FFFF_FFF8, 16, 3'd0, "R7");
            send(64'h2008, 8, 3'd1, "R2");
            send(64'h2004, 8, 3'd1, "R2");
            send(64'h2006, 3, 3'd1, "R2");
            send(64'h0030, 16, 3'd1, "R2");
            send(64'h0038, 16, 3'd1, "R2");
            send(64'h0018, 16, 3'd2, "R3");
            send(64'h0020, 16, 3'd2, "R3");
            send(64'h1003, 8, 3'd2, "R3");
            send(64'h103D, 4, 3'd2, "R3");
            send(64'h1002, 4, 3'd4, "R4");
            send(64'h1004, 4, 3'd4, "R4");
            send(64'h1001, 4, 3'd4, "R4");
            send(64'h4000, 0, 3'd0, "R5");
            send(64'h4000, 17, 3'd3, "R5");
            send(64'h4010, 0, 3'd1, "R5");
            drain();
        end

        // pulse lasts one cycle and the address holds afterwards
        send(64'hABCD_0001, 4, 3'd4, "R10");
        @(negedge clk);
        chk(fault_pulse === 1'b0, "R10", "pulse width", 64'(fault_pulse), 64'd0);
        send(64'h3000, 4, 3'd0, "R11");
        drain();
        chk(far_addr === 64'hABCD_0001, "R11", "far hold", far_addr, 64'hABCD_0001);

        // synchronous reset clears the fault address
        @(negedge clk);
        rst = 1'b1;
        far_model = '0;
        repeat (2) @(negedge clk);
        reset_checks("R11");
        rst = 1'b0;
        send(64'h0041, 2, 3'd0, "R6");
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule